// File: doc/BRIEF.md
# Sign-Magnitude Fractional Shift-Add Multiplier

This block multiplies two fractional numbers held in sign-magnitude form and returns a rounded product of the same width. Each operand word carries a sign in its top bit and a magnitude fraction below it. The binary point sits directly above the magnitude MSB, so every magnitude is less than one. A one-cycle `start` pulse captures both operands. The magnitudes are kept, and the product sign is recorded as the exclusive-or of the two operand signs.

The computation is sequential. The multiplicand sits in a storage register that never shifts. The multiplier goes into the low half of a double-length accumulator, and that low half also acts as the accumulator's shifting extension. On each step the lowest multiplier bit selects whether the multiplicand or zero is added into the upper accumulator half. The whole pair then shifts right by one place. After one step per magnitude bit, one further cycle adds a rounding one just below the kept places. That cycle takes the place of the step for the multiplier sign, which would always be zero. The result goes out with a one-cycle `done` pulse and then holds until the next result replaces it.

Top module: `sm_frac_mul`

## Requirements
- R1: While `rst_n` is low at a clock edge, `done` and `product` are both cleared to 0 at that edge.
- R2: Operands and product use the same format: bit W-1 is the sign (1 means negative) and bits W-2..0 are the magnitude, a fraction with the binary point above bit W-2. Here M = W-1.
- R3: The product magnitude equals (|a|·|b| + 2^(M-1)) >> M, where |a| and |b| are the M-bit magnitudes. The rounding one is added just below the M kept places, and its carry propagates into them. For W=5, 0.1011 × 0.1110 gives 0.1010.
- R4: The product sign bit equals sign(a) XOR sign(b). This holds even when the rounded magnitude is zero.
- R5: When `start` is high at clock edge k while the block is idle, `done` is high after edge k+M+1 for exactly one cycle.
- R6: A `start` received while a multiplication is in progress is ignored. The running result and its `done` timing are unchanged, and no second result follows.
- R7: `product` changes only at the edge that raises `done`, and it keeps its value through the whole of the next multiplication.
- R8: Magnitude corner cases follow R3: a zero multiplier or multiplicand gives magnitude 0, and all-ones times all-ones gives 2^M-2 with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a multiplication with the present operands (taken only when idle) |
| op_a | input | W | Multiplicand, sign-magnitude fraction |
| op_b | input | W | Multiplier, sign-magnitude fraction |
| done | output | 1 | One-cycle pulse marking a new product |
| product | output | W | Rounded sign-magnitude product, held between results |

## Verification
The only timed result is the product. It appears together with `done` M+1 cycles after the edge that accepted `start`: M shift-add steps plus one rounding cycle. The bench drives inputs on falling edges. It then samples on each later falling edge, requiring `done` low and `product` unchanged for the first M samples, and `done` high with the expected value on sample M+1. The sample after that must show `done` low again. A second `start`, raised in the middle of a run, must leave both the pulse position and the value unchanged.

// File: rtl/sm_mul_pkg.sv
// Package: shared types for the sign-magnitude fractional multiplier.
// Assumes nothing beyond IEEE 1800-2017 packages.
package sm_mul_pkg;

    // Sequencer phases: waiting, shift-add steps, rounding cycle.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_STEP  = 2'd1,
        PH_ROUND = 2'd2
    } mul_phase_e;

endpackage

// File: rtl/sm_mul_operand.sv
// Module: sm_mul_operand
// Splits one sign-magnitude operand into its sign flag and its positive
// magnitude. Clearing the sign is the whole conversion to positive form.
// Assumes W >= 3.
module sm_mul_operand #(
    parameter int W = 8
) (
    input  logic [W-1:0] word_in,
    output logic         neg_out,
    output logic [W-2:0] mag_out
);

    // Separate sign from magnitude.
    always_comb begin
        neg_out = word_in[W-1];
        mag_out = word_in[W-2:0];
    end

endmodule

// File: rtl/sm_mul_ctrl.sv
// Module: sm_mul_ctrl
// Sequences one multiplication: a load on an accepted start, M shift-add
// steps and one rounding cycle. It then raises a one-cycle done pulse.
// A start is taken only in the idle phase.
module sm_mul_ctrl
    import sm_mul_pkg::*;
#(
    parameter int M = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic round_en,
    output logic done
);

    localparam int CW = $clog2(M + 1);

    mul_phase_e     phase;
    logic [CW-1:0]  step_cnt;

    // Phase register, step counter and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            step_cnt <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase    <= PH_STEP;
                        step_cnt <= '0;
                    end
                end
                PH_STEP: begin
                    step_cnt <= step_cnt + 1'b1;
                    if (step_cnt == CW'(M - 1)) begin
                        phase <= PH_ROUND;
                    end
                end
                PH_ROUND: begin
                    phase <= PH_IDLE;
                    done  <= 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Decode the datapath commands from the phase.
    always_comb begin
        load     = (phase == PH_IDLE) && start;
        step     = (phase == PH_STEP);
        round_en = (phase == PH_ROUND);
    end

    // R5: done lasts exactly one cycle.
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: only one datapath command is active in any cycle.
    a_r5_one_command: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load, step, round_en}));

    // R6: a start during the steps neither restarts nor stops the run.
    a_r6_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (step && start) |=> (step || round_en));

    // R5: the step count never passes the magnitude width.
    a_r5_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (step_cnt < CW'(M)));

endmodule

// File: rtl/sm_mul_datapath.sv
// Module: sm_mul_datapath
// Holds the multiplicand in a fixed register. The multiplier shares the
// low half of the double-length accumulator with the shifting extension.
// Each step adds the multiplicand or zero, chosen by the low multiplier
// bit, and then shifts the pair right. The rounding cycle adds one just
// below the kept places and registers the signed product.
module sm_mul_datapath #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         round_en,
    input  logic         a_neg,
    input  logic [W-2:0] a_mag,
    input  logic         b_neg,
    input  logic [W-2:0] b_mag,
    output logic [W-1:0] product
);

    localparam int M = W - 1;

    logic [M-1:0] mcand_q;
    logic [M-1:0] acc_hi;
    logic [M-1:0] acc_ext;
    logic         neg_q;
    logic [M:0]   part_sum;
    logic [M-1:0] rounded;

    // Partial sum with a carry place for the add before the shift.
    always_comb begin
        part_sum = {1'b0, acc_hi} + (acc_ext[0] ? {1'b0, mcand_q} : '0);
    end

    // Rounding: add the top extension bit into the accumulating half.
    always_comb begin
        rounded = acc_hi + {{(M-1){1'b0}}, acc_ext[M-1]};
    end

    // Operand capture, shift-add steps and product register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q <= '0;
            acc_hi  <= '0;
            acc_ext <= '0;
            neg_q   <= 1'b0;
            product <= '0;
        end else if (load) begin
            mcand_q <= a_mag;
            acc_hi  <= '0;
            acc_ext <= b_mag;
            neg_q   <= a_neg ^ b_neg;
        end else if (step) begin
            acc_hi  <= part_sum[M:1];
            acc_ext <= {part_sum[0], acc_ext[M-1:1]};
        end else if (round_en) begin
            product <= {neg_q, rounded};
        end
    end

    // R8: the rounding carry never runs out of the kept places.
    a_r8_round_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        round_en |-> !((&acc_hi) && acc_ext[M-1]));

    // R3: the multiplicand register does not move during the steps.
    a_r3_mcand_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> $stable(mcand_q));

endmodule

// File: rtl/sm_frac_mul.sv
// Module: sm_frac_mul (top)
// Sign-magnitude fractional multiplier with a start/done handshake.
// Takes W-bit operands and gives a W-bit rounded product after M+1 cycles,
// where M = W-1. Assumes W >= 3 and a single synchronous clock domain.
module sm_frac_mul #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         done,
    output logic [W-1:0] product
);

    localparam int M = W - 1;

    logic [W-1:0] op_words [2];
    logic [1:0]   op_neg;
    logic [M-1:0] op_mag   [2];
    logic         load;
    logic         step;
    logic         round_en;

    // Gather the operands for the conversion units.
    always_comb begin
        op_words[0] = op_a;
        op_words[1] = op_b;
    end

    // One sign/magnitude splitter per operand.
    for (genvar g = 0; g < 2; g++) begin : g_conv
        sm_mul_operand #(.W(W)) u_conv (
            .word_in (op_words[g]),
            .neg_out (op_neg[g]),
            .mag_out (op_mag[g])
        );
    end

    sm_mul_ctrl #(.M(M)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .load     (load),
        .step     (step),
        .round_en (round_en),
        .done     (done)
    );

    sm_mul_datapath #(.W(W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .round_en (round_en),
        .a_neg    (op_neg[0]),
        .a_mag    (op_mag[0]),
        .b_neg    (op_neg[1]),
        .b_mag    (op_mag[1]),
        .product  (product)
    );

    // R7: the product changes only together with the done pulse.
    a_r7_product_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(product) |-> done);

endmodule

// File: tb/tb_sm_frac_mul.sv
`timescale 1ns/1ps
// Bench for sm_frac_mul: directed corner cases plus seeded random operands.
module tb_sm_frac_mul;

    localparam int W = 8;
    localparam int M = W - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         done;
    logic [W-1:0] product;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    sm_frac_mul #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .op_a(op_a), .op_b(op_b), .done(done), .product(product)
    );

    always #2 clk = ~clk;

    // Expected product from R2, R3, R4.
    function automatic logic [W-1:0] exp_prod(input logic [W-1:0] a, input logic [W-1:0] b);
        int unsigned p;
        p = (int'(a[W-2:0]) * int'(b[W-2:0]) + (1 << (M - 1))) >> M;
        return {a[W-1] ^ b[W-1], p[M-1:0]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One multiplication; optionally a second start mid-run (R6).
    task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b, input bit extra_start);
        logic [W-1:0] prev;
        logic [W-1:0] want;
        prev = product;
        want = exp_prod(a, b);
        @(negedge clk);
        op_a = a; op_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R5 no early done", {7'd0, done}, '0);
        for (int i = 1; i <= M + 1; i++) begin
            if (extra_start && i == 2) begin
                op_a = ~a; op_b = ~b; start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            if (i <= M) begin
                check(done == 1'b0, "R5 done timing", {7'd0, done}, '0);
                check(product == prev, "R7 product hold", product, prev);
            end else begin
                check(done == 1'b1, "R5 done at M+1", {7'd0, done}, 8'd1);
                check(product == want, "R3 R4 product value", product, want);
            end
        end
        @(negedge clk);
        check(done == 1'b0, "R5 pulse one cycle", {7'd0, done}, '0);
        check(product == want, "R7 hold after done", product, want);
        if (extra_start) begin
            for (int i = 0; i < M + 2; i++) begin
                @(negedge clk);
                check(done == 1'b0, "R6 ignored start gives no result", {7'd0, done}, '0);
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                fails++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<=20000", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        logic [W-1:0] ra;
        logic [W-1:0] rb;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1 reset done", {7'd0, done}, '0);
        check(product == '0, "R1 reset product", product, '0);
        rst_n = 1'b1;
        // R3 document example scaled to W=8: 0.1011000 x 0.1110000.
        run_mul(8'h58, 8'h70, 1'b0);
        // R4 signs, including negative zero magnitude.
        run_mul(8'hD8, 8'h70, 1'b0);
        run_mul(8'hD8, 8'hF0, 1'b0);
        run_mul(8'h80, 8'h3F, 1'b0);
        // R8 corners: zero operands and all-ones.
        run_mul(8'h55, 8'h00, 1'b0);
        run_mul(8'h00, 8'h7F, 1'b0);
        run_mul(8'h7F, 8'h7F, 1'b0);
        run_mul(8'hFF, 8'h7F, 1'b0);
        // R3 rounding carry: 1/128 * 64/128 rounds up to 1/128.
        run_mul(8'h01, 8'h40, 1'b0);
        run_mul(8'h01, 8'h3F, 1'b0);
        // R6 start during a run.
        run_mul(8'h2B, 8'h5E, 1'b1);
        // Random operands.
        for (int n = 0; n < 60; n++) begin
            ra = W'($urandom);
            rb = W'($urandom);
            run_mul(ra, rb, (n % 7) == 3);
        end
        // R1 reset again mid-idle.
        rst_n = 1'b0;
        @(negedge clk);
        check(product == '0, "R1 reset clears product", product, '0);
        check(done == 1'b0, "R1 reset clears done", {7'd0, done}, '0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule